// File: doc/BRIEF.md
# Gated Masked Port Logic Unit

This block combines two 32-bit input ports, A and B, onto one 32-bit output port, C. Each input channel can be masked by software. A 4-bit mode field picks what reaches C: masked A, masked B, their bitwise AND, or their bitwise OR. Each of these can be passed through live while a gate is open, or latched at the opening of the gate and held. Other modes show a free-running cycle counter or a value that software writes.

The gate is the OR of an external gate input and a software gate flag. The flag is set and cleared by strobe bits in the control word. A clear, from an external input or from a software strobe, empties the capture latch and drops data ready. A small synchronous register bus reads and writes the mask, control and value registers. The same bus reads a status word that shows data ready and each gate and clear source.

Top module: `gml_unit`

## Requirements
- R1: On a synchronous active-high reset, every register (masks, mode, level select, value, software gate, capture latch, data ready, counter) goes to zero. Port C and every register read then return zero.
- R2: A 1 in bit n of the A mask (offset 0x1800) or the B mask (offset 0x1804) forces channel n of that port to 0 before any combination takes place.
- R3: Control bits [3:0] select the mode. Mode 0 gives masked A, mode 1 masked B, mode 2 their AND and mode 3 their OR, all live on C while the gate is open. In modes 0 to 3, C is zero while the gate is closed.
- R4: Modes 4, 5, 6 and 7 use the sources of modes 0, 1, 2 and 3. On the first clock edge at which the gate is open after being closed, the source value is latched and data ready is set. C shows the latched value, which holds until the next gate opening or a clear.
- R5: In mode 8, C shows a counter that is 0 in the first cycle after reset and goes up by one on every clock edge.
- R6: In modes 9 to 15, C shows the value register, which is read/write at offset 0x180C.
- R7: A control write (offset 0x1808) with bit 4 set opens the software gate from the next cycle. A write with bit 5 set closes it, and bit 5 wins when both bits are set. The effective gate is the external gate input OR the software gate.
- R8: Control bit 8 is stored and driven on level_sel.
- R9: A control write with bit 6 set gives a software clear in the following cycle. That clear, or a high ext_clear, zeroes the capture latch and data ready at the next edge, and it wins over a capture at the same edge.
- R10: Status (offset 0x1010, read-only) reads bit 0 data ready, bit 1 ext_gate, bit 2 ext_clear, bit 3 the software gate and bit 4 the software clear, with bits [31:5] zero.
- R11: A control read returns bits [3:0] and bit 8 with every other bit zero. Reads of unmapped offsets return zero, and writes to status or to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Register byte offset for reads and writes |
| bus_we | input | 1 | Write strobe, taken on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| port_a | input | 32 | Input port A |
| port_b | input | 32 | Input port B |
| ext_gate | input | 1 | External gate, active high |
| ext_clear | input | 1 | External clear, active high |
| port_c | output | 32 | Output port C |
| level_sel | output | 1 | Stored control bit 8 |

## Verification
The assertions assume that every input is synchronous to clk and steady between edges, and that the bus needs no handshake: one write strobe is taken per edge. The stimulus changes inputs shortly after each rising edge and holds them for the whole cycle. It pulses gates and clears in all orders, including a clear at the same edge as a gate opening and both software gate bits in one write. The bench model is checked on every falling edge against port C, level_sel and the read data at the current address.

// File: rtl/gml_pkg.sv
package gml_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 16;
    localparam int MODE_W   = 4;
    localparam int STAT_W   = 5;

    localparam logic [ADDR_W-1:0] OFS_STATUS = 16'h1010;
    localparam logic [ADDR_W-1:0] OFS_MASK_A = 16'h1800;
    localparam logic [ADDR_W-1:0] OFS_MASK_B = 16'h1804;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 16'h1808;
    localparam logic [ADDR_W-1:0] OFS_VALUE  = 16'h180C;

    localparam int CB_START = 4;
    localparam int CB_STOP  = 5;
    localparam int CB_CLEAR = 6;
    localparam int CB_LEVEL = 8;

    typedef enum logic [1:0] {
        OP_A   = 2'd0,
        OP_B   = 2'd1,
        OP_AND = 2'd2,
        OP_OR  = 2'd3
    } comb_op_e;

    typedef enum logic [1:0] {
        SEL_LIVE,
        SEL_HELD,
        SEL_COUNT,
        SEL_VALUE
    } out_sel_e;

    typedef struct packed {
        out_sel_e sel;
        comb_op_e op;
    } mode_dec_t;

    typedef struct packed {
        logic sw_clear;
        logic sw_gate;
        logic ext_clear;
        logic ext_gate;
        logic ready;
    } status_t;

    function automatic mode_dec_t decode_mode(input logic [MODE_W-1:0] m);
        mode_dec_t d;
        d.op = comb_op_e'(m[1:0]);
        if (m[3]) begin
            d.sel = (m == 4'd8) ? SEL_COUNT : SEL_VALUE;
        end else begin
            d.sel = m[2] ? SEL_HELD : SEL_LIVE;
        end
        return d;
    endfunction

    function automatic logic [DATA_W-1:0] combine(
        input comb_op_e          op,
        input logic [DATA_W-1:0] a,
        input logic [DATA_W-1:0] b
    );
        case (op)
            OP_A:    return a;
            OP_B:    return b;
            OP_AND:  return a & b;
            default: return a | b;
        endcase
    endfunction

endpackage

// File: rtl/gml_regs.sv
module gml_regs
    import gml_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  status_t           status,
    output logic [DATA_W-1:0] mask_a,
    output logic [DATA_W-1:0] mask_b,
    output logic [MODE_W-1:0] mode,
    output logic              level,
    output logic [DATA_W-1:0] value,
    output logic              start_req,
    output logic              stop_req,
    output logic              clear_req
);

    localparam int PAD_CTRL = DATA_W - CB_LEVEL - 1;
    localparam int PAD_STAT = DATA_W - STAT_W;

    logic wr_ctrl;

    assign wr_ctrl   = bus_we && (bus_addr == OFS_CTRL);
    assign start_req = wr_ctrl && bus_wdata[CB_START];
    assign stop_req  = wr_ctrl && bus_wdata[CB_STOP];
    assign clear_req = wr_ctrl && bus_wdata[CB_CLEAR];

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_a <= '0;
            mask_b <= '0;
            mode   <= '0;
            level  <= 1'b0;
            value  <= '0;
        end else if (bus_we) begin
            case (bus_addr)
                OFS_MASK_A: mask_a <= bus_wdata;
                OFS_MASK_B: mask_b <= bus_wdata;
                OFS_VALUE:  value  <= bus_wdata;
                OFS_CTRL: begin
                    mode  <= bus_wdata[MODE_W-1:0];
                    level <= bus_wdata[CB_LEVEL];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_MASK_A: bus_rdata = mask_a;
            OFS_MASK_B: bus_rdata = mask_b;
            OFS_VALUE:  bus_rdata = value;
            OFS_CTRL:   bus_rdata = {{PAD_CTRL{1'b0}}, level,
                                     {(CB_LEVEL-MODE_W){1'b0}}, mode};
            OFS_STATUS: bus_rdata = {{PAD_STAT{1'b0}}, status};
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gml_gate.sv
module gml_gate
    import gml_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_gate,
    input  logic              ext_clear,
    input  logic              start_req,
    input  logic              stop_req,
    input  logic              clear_req,
    input  out_sel_e          sel,
    input  logic [DATA_W-1:0] src,
    output logic              gate,
    output logic              sw_gate,
    output logic              sw_clear,
    output logic              gate_q,
    output logic              ready,
    output logic [DATA_W-1:0] held
);

    logic clr;
    logic opening;

    assign gate    = ext_gate | sw_gate;
    assign clr     = ext_clear | sw_clear;
    assign opening = gate && !gate_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_gate  <= 1'b0;
            sw_clear <= 1'b0;
            gate_q   <= 1'b0;
        end else begin
            sw_clear <= clear_req;
            gate_q   <= gate;
            if (stop_req) begin
                sw_gate <= 1'b0;
            end else if (start_req) begin
                sw_gate <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held  <= '0;
            ready <= 1'b0;
        end else if (clr) begin
            held  <= '0;
            ready <= 1'b0;
        end else if (opening && sel == SEL_HELD) begin
            held  <= src;
            ready <= 1'b1;
        end
    end

endmodule

// File: rtl/gml_counter.sv
module gml_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/gml_unit.sv
module gml_unit
    import gml_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] port_a,
    input  logic [DATA_W-1:0] port_b,
    input  logic              ext_gate,
    input  logic              ext_clear,
    output logic [DATA_W-1:0] port_c,
    output logic              level_sel
);

    logic [DATA_W-1:0] mask_a, mask_b, value, held, count, src;
    logic [MODE_W-1:0] mode;
    logic              start_req, stop_req, clear_req;
    logic              gate, sw_gate, sw_clear, gate_q, ready;
    mode_dec_t         dec;
    status_t           status;

    assign dec = decode_mode(mode);
    assign src = combine(dec.op, port_a & ~mask_a, port_b & ~mask_b);

    assign status.ready     = ready;
    assign status.ext_gate  = ext_gate;
    assign status.ext_clear = ext_clear;
    assign status.sw_gate   = sw_gate;
    assign status.sw_clear  = sw_clear;

    gml_regs u_regs (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .status(status),
        .mask_a(mask_a), .mask_b(mask_b), .mode(mode), .level(level_sel),
        .value(value), .start_req(start_req), .stop_req(stop_req),
        .clear_req(clear_req)
    );

    gml_gate u_gate (
        .clk(clk), .rst(rst),
        .ext_gate(ext_gate), .ext_clear(ext_clear),
        .start_req(start_req), .stop_req(stop_req), .clear_req(clear_req),
        .sel(dec.sel), .src(src),
        .gate(gate), .sw_gate(sw_gate), .sw_clear(sw_clear),
        .gate_q(gate_q), .ready(ready), .held(held)
    );

    gml_counter #(.CNT_W(DATA_W)) u_count (
        .clk(clk), .rst(rst), .count(count)
    );

    always_comb begin
        case (dec.sel)
            SEL_LIVE:  port_c = gate ? src : '0;
            SEL_HELD:  port_c = held;
            SEL_COUNT: port_c = count;
            default:   port_c = value;
        endcase
    end

endmodule

// File: rtl/gml_unit_chk.sv
module gml_unit_chk
    import gml_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] port_c,
    input logic [MODE_W-1:0] mode,
    input logic              gate,
    input logic              gate_q,
    input logic              sw_gate,
    input logic              sw_clear,
    input logic              ext_clear,
    input logic              ready,
    input logic [DATA_W-1:0] held,
    input logic [DATA_W-1:0] count
);

    logic ctrl_wr;
    assign ctrl_wr = bus_we && bus_addr == OFS_CTRL;

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (ready == 1'b0 && sw_gate == 1'b0 && count == '0));

    assert_live_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (mode < 4'd4 && !gate) |-> port_c == '0);

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!(gate && !gate_q) && !ext_clear && !sw_clear) |=> $stable(held));

    assert_ready_src_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(gate && !gate_q));

    assert_counter_R5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> count == $past(count) + 1'b1);

    assert_sw_stop_R7: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && bus_wdata[CB_STOP]) |=> !sw_gate);

    assert_sw_start_R7: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && bus_wdata[CB_START] && !bus_wdata[CB_STOP]) |=> sw_gate);

    assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (ext_clear || sw_clear) |=> (!ready && held == '0));

    assert_status_pad_R10: assert property (@(posedge clk) disable iff (rst)
        bus_addr == OFS_STATUS |-> bus_rdata[DATA_W-1:STAT_W] == '0);

endmodule

bind gml_unit gml_unit_chk u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .port_c(port_c),
    .mode(mode), .gate(gate), .gate_q(gate_q), .sw_gate(sw_gate),
    .sw_clear(sw_clear), .ext_clear(ext_clear), .ready(ready),
    .held(held), .count(count)
);

// File: tb/gml_unit_test.sv
`timescale 1ns/1ps
module gml_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = 16'h0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [31:0] port_a = 32'h0;
    logic [31:0] port_b = 32'h0;
    logic        ext_gate = 1'b0;
    logic        ext_clear = 1'b0;
    logic [31:0] port_c;
    logic        level_sel;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gml_unit uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .port_a(port_a),
        .port_b(port_b), .ext_gate(ext_gate), .ext_clear(ext_clear),
        .port_c(port_c), .level_sel(level_sel)
    );

    // Behavioural reference state
    logic [31:0] m_ma, m_mb, m_val, m_cap, m_cnt;
    int          m_mode;
    bit          m_lvl, m_sg, m_sc, m_gprev, m_rdy;

    function automatic logic [31:0] ref_src();
        logic [31:0] a, b;
        a = port_a & ~m_ma;
        b = port_b & ~m_mb;
        case (m_mode % 4)
            0: return a;
            1: return b;
            2: return a & b;
            default: return a | b;
        endcase
    endfunction

    function automatic logic [31:0] ref_c();
        bit g;
        g = ext_gate | m_sg;
        if (m_mode < 4) return g ? ref_src() : 32'h0;
        if (m_mode < 8) return m_cap;
        if (m_mode == 8) return m_cnt;
        return m_val;
    endfunction

    function automatic logic [31:0] ref_rd();
        case (bus_addr)
            16'h1800: return m_ma;
            16'h1804: return m_mb;
            16'h180C: return m_val;
            16'h1808: return (32'(m_lvl) << 8) | 32'(m_mode);
            16'h1010: return {27'h0, m_sc, m_sg, ext_clear, ext_gate, m_rdy};
            default:  return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ma = 0; m_mb = 0; m_val = 0; m_cap = 0; m_cnt = 0;
            m_mode = 0; m_lvl = 0; m_sg = 0; m_sc = 0; m_gprev = 0; m_rdy = 0;
        end else begin
            bit g, clr, wc;
            logic [31:0] s;
            g   = ext_gate | m_sg;
            clr = ext_clear | m_sc;
            s   = ref_src();
            if (clr) begin
                m_cap = 0; m_rdy = 0;
            end else if (g && !m_gprev && m_mode >= 4 && m_mode < 8) begin
                m_cap = s; m_rdy = 1;
            end
            m_gprev = g;
            wc = bus_we && bus_addr == 16'h1808;
            m_sc = wc && bus_wdata[6];
            if (wc) begin
                if (bus_wdata[5]) m_sg = 0;
                else if (bus_wdata[4]) m_sg = 1;
                m_mode = int'(bus_wdata[3:0]);
                m_lvl  = bus_wdata[8];
            end
            if (bus_we && bus_addr == 16'h1800) m_ma = bus_wdata;
            if (bus_we && bus_addr == 16'h1804) m_mb = bus_wdata;
            if (bus_we && bus_addr == 16'h180C) m_val = bus_wdata;
            m_cnt = m_cnt + 1;
        end
    end

    function automatic string c_tag();
        if (rst) return "R1";
        if (m_mode < 4) return (m_ma | m_mb) != 0 ? "R2/R3" : "R3";
        if (m_mode < 8) return m_rdy ? "R4" : "R9/R4";
        if (m_mode == 8) return "R5";
        return "R6";
    endfunction

    function automatic string rd_tag();
        case (bus_addr)
            16'h1010: return "R10";
            16'h180C: return "R6";
            16'h1808: return "R11/R7";
            16'h1800, 16'h1804: return "R2";
            default:  return "R11";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done && $time > 30) begin
            check(c_tag(), port_c, ref_c());
            check(rd_tag(), bus_rdata, ref_rd());
            check("R8", 32'(level_sel), 32'(m_lvl));
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a);
        bus_addr = a;
        step();
    endtask

    initial begin
        #400000;
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual hung expected finish");
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        step(); step(); step();
        rst = 1'b0;
        // R1: reset values on every map offset
        rd(16'h1800); rd(16'h1804); rd(16'h1808); rd(16'h180C); rd(16'h1010);
        port_a = 32'hF0F0_1234; port_b = 32'h0FF0_5678;
        // R3 live modes, gate closed then external gate open
        for (int m = 0; m < 4; m++) begin
            wr(16'h1808, 32'(m));
            rd(16'h1010);
            ext_gate = 1'b1; rd(16'h1010);
            port_a = port_a ^ 32'h0101_0101; step();
            ext_gate = 1'b0; step();
        end
        // R2 masks with software gate (R7)
        wr(16'h1800, 32'hFF00_00FF);
        wr(16'h1804, 32'h0000_FFFF);
        for (int m = 0; m < 4; m++) begin
            wr(16'h1808, 32'h10 | 32'(m));
            rd(16'h1808); step();
            wr(16'h1808, 32'h20 | 32'(m));
            step();
        end
        // R7 both bits: stop wins
        wr(16'h1808, 32'h10);
        wr(16'h1808, 32'h30); rd(16'h1010);
        wr(16'h1800, 32'h0); wr(16'h1804, 32'h0);
        // R4 capture modes
        for (int m = 4; m < 8; m++) begin
            wr(16'h1808, 32'(m));
            port_a = 32'hA5A5_0000 + 32'(m); port_b = 32'h5A5A_FFFF - 32'(m);
            ext_gate = 1'b1; step();
            port_a = 32'hDEAD_BEEF; step(); rd(16'h1010);
            ext_gate = 1'b0; step(); step();
            ext_gate = 1'b1; port_b = 32'h1234_0000; step();
            ext_gate = 1'b0; step();
            // R9 external clear
            ext_clear = 1'b1; rd(16'h1010);
            ext_clear = 1'b0; step();
        end
        // R9 clear at the same edge as gate opening, and software clear
        wr(16'h1808, 32'h6);
        ext_gate = 1'b1; ext_clear = 1'b1; step();
        ext_clear = 1'b0; step(); ext_gate = 1'b0; step();
        ext_gate = 1'b1; step(); ext_gate = 1'b0; rd(16'h1010);
        wr(16'h1808, 32'h46); rd(16'h1010); step();
        // R5 counter and R6 value register, R8 level
        wr(16'h1808, 32'h108);
        repeat (5) step();
        wr(16'h180C, 32'hCAFE_F00D);
        for (int m = 9; m < 16; m++) begin
            wr(16'h1808, 32'(m)); rd(16'h180C);
        end
        // R11 writes to status and unmapped offsets ignored
        wr(16'h1010, 32'hFFFF_FFFF); rd(16'h1010);
        wr(16'h1234, 32'hFFFF_FFFF); rd(16'h1234);
        rd(16'h1800); rd(16'h1808); rd(16'h180C);
        // R1 reset mid-run
        rst = 1'b1; step(); step(); rst = 1'b0;
        rd(16'h1808); rd(16'h180C); rd(16'h1010); step();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule